// File: doc/BRIEF.md
# Load/Store Circular Queue Controller

This block keeps the bookkeeping for one thread's memory instructions. It has two circular buffers: one for loads and one for stores. Each ring holds a head pointer, a tail pointer and an occupancy count. The store ring also holds a writeback pointer. The front end allocates entries in program order and tags each one with a sequence number. The block then retires loads at commit. Stores advance through four stages: filled, committed, eligible for writeback, and completed. A store slot is given back only when memory reports that its write has finished.

Each ring has one more slot than it can hold instructions, and the extra slot stays unused so that head equal to tail always means empty. A commit operation names a youngest sequence number and acts on every older entry. A squash operation names a sequence number and discards every younger entry that has not been committed. The block reports per-ring and combined full flags, the number of instructions that can still be accepted, and the number of stores waiting to go to memory. Each cycle it also offers the store at the writeback pointer to the memory side.

Top module: `lsq_ring_ctrl`

## Requirements
- R1: After a synchronous reset both rings are empty. Both counts and the pending-store count read 0, no full flag is set, no store is offered, and the free count equals the smaller of the two usable depths.
- R2: An allocation request is accepted when its ring is not full. The accepted entry takes the slot index shown on the alloc index output in that same cycle, and the ring count rises by one after the clock edge.
- R3: A ring is full when its count equals its slot total minus one, which is its usable depth. The unit full flag is the OR of both ring flags. Allocations to a full ring are dropped.
- R4: The free count equals the minimum of (load usable depth − load count) and (store usable depth − store count).
- R5: A commit with value C releases, from the load head, every load whose sequence number is below C. The load count drops by that many after the edge.
- R6: A commit with value C marks every store older than C as committed. A store becomes eligible for writeback once it is both committed and filled with data. The pending count is the number of eligible stores not yet sent, and the any-pending flag is high exactly when that count is non-zero.
- R7: A store is offered to memory when the entry at the writeback pointer is valid, eligible and not completed, and mem_block is low. The offer carries that entry's index, size and data. An offer is taken in the same cycle it appears, after which the writeback pointer advances.
- R8: Store slots are released in order from the head, at most one per cycle. A slot is released only after a done report has arrived for a store that was already sent. Fills and done reports naming slots that are not eligible for them are ignored.
- R9: A squash with value S removes, walking back from the tail, every uncommitted entry whose sequence number is greater than S. Committed and in-flight stores are never removed. During a squash cycle, allocations and any commit are ignored.
- R10: Head, tail and writeback pointers wrap modulo the slot total, which does not have to be a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_alloc_vld | input | 1 | Request a load entry |
| ld_alloc_seq | input | SEQ_W | Sequence number of the load |
| ld_alloc_ok | output | 1 | Load request accepted this cycle |
| ld_alloc_idx | output | LD_W | Slot given to the load |
| st_alloc_vld | input | 1 | Request a store entry |
| st_alloc_seq | input | SEQ_W | Sequence number of the store |
| st_alloc_ok | output | 1 | Store request accepted this cycle |
| st_alloc_idx | output | ST_W | Slot given to the store |
| st_fill_vld | input | 1 | Write size and data into a store slot |
| st_fill_idx | input | ST_W | Store slot to fill |
| st_fill_size | input | SIZE_W | Access size in bytes |
| st_fill_data | input | DATA_W | Store data |
| commit_vld | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Entries older than this commit |
| squash_vld | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| mem_block | input | 1 | Memory side cannot take a store |
| mem_done_vld | input | 1 | A sent store has finished |
| mem_done_idx | input | ST_W | Slot of the finished store |
| st_send_vld | output | 1 | Store offered to memory this cycle |
| st_send_idx | output | ST_W | Slot of the offered store |
| st_send_size | output | SIZE_W | Size of the offered store |
| st_send_data | output | DATA_W | Data of the offered store |
| ld_cnt | output | LD_W | Loads held |
| st_cnt | output | ST_W | Stores held |
| ld_full | output | 1 | Load ring full |
| st_full | output | 1 | Store ring full |
| lsq_full | output | 1 | Either ring full |
| free_cnt | output | FR_W | Instructions that can still be accepted |
| st_wb_pend | output | ST_W | Eligible stores not yet sent |
| st_wb_any | output | 1 | Pending count non-zero |

## Verification
The accept flags, alloc indexes and the store offer all depend on registered state combined with same-cycle inputs, so they are due in the cycle the stimulus is applied. The bench samples them 1 ns after driving the inputs, before the clock edge. Counts, full flags, the free count and the pending count are registered and change one edge after the stimulus, so the bench samples them 1 ns after that edge. A bench-side model tracks the expected state using a walk-from-head and walk-from-tail formulation.

// File: rtl/lsq_ring_pkg.sv
package lsq_ring_pkg;

  typedef struct packed {
    logic valid;
    logic filled;
    logic committed;
    logic can_wb;
    logic sent;
    logic completed;
  } st_flags_t;

  // Step a ring pointer by n (may be negative) modulo slots.
  function automatic int ring_step(input int p, input int n, input int slots);
    int s;
    s = p + n;
    if (s >= slots) s = s - slots;
    if (s < 0) s = s + slots;
    return s;
  endfunction

endpackage

// File: rtl/lsq_load_ring.sv
module lsq_load_ring #(
  parameter int USABLE = 7,
  parameter int SEQ_W  = 16,
  localparam int SLOTS = USABLE + 1,
  localparam int W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_vld,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic             commit_vld,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             squash_vld,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic             alloc_ok,
  output logic [W-1:0]     alloc_idx,
  output logic [W-1:0]     cnt,
  output logic             full
);
  import lsq_ring_pkg::*;

  logic [SLOTS-1:0] vld_q;
  logic [SEQ_W-1:0] seq_q [SLOTS];
  logic [W-1:0]     head_q, tail_q, cnt_q;
  logic [SLOTS-1:0] cmask, smask;
  int               ccnt, scnt;

  assign full      = (int'(cnt_q) == SLOTS - 1);
  assign alloc_ok  = alloc_vld && !full && !squash_vld;
  assign alloc_idx = tail_q;
  assign cnt       = cnt_q;

  always_comb begin
    ccnt = 0;
    scnt = 0;
    for (int i = 0; i < SLOTS; i++) begin
      cmask[i] = commit_vld && !squash_vld && vld_q[i] && (seq_q[i] < commit_seq);
      smask[i] = squash_vld && vld_q[i] && (seq_q[i] > squash_seq);
      ccnt += int'(cmask[i]);
      scnt += int'(smask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (alloc_ok && tail_q == W'(i)) vld_q[i] <= 1'b1;
        else if (cmask[i] || smask[i])   vld_q[i] <= 1'b0;
      end
      head_q <= W'(ring_step(int'(head_q), ccnt, SLOTS));
      if (squash_vld)    tail_q <= W'(ring_step(int'(tail_q), -scnt, SLOTS));
      else if (alloc_ok) tail_q <= W'(ring_step(int'(tail_q), 1, SLOTS));
      cnt_q <= W'(int'(cnt_q) + int'(alloc_ok) - ccnt - scnt);
    end
  end

  // Sequence storage: written at the tail only, no reset needed.
  always_ff @(posedge clk) begin
    if (alloc_ok) seq_q[tail_q] <= alloc_seq;
  end

  // R5: head only moves under a commit
  p_head_commit_only_r5: assert property (@(posedge clk) disable iff (rst)
    !commit_vld |=> head_q == $past(head_q));
  // R3: a full ring does not grow
  p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !commit_vld) |=> cnt_q <= $past(cnt_q));
  // R9: squash never grows the ring
  p_squash_shrink_r9: assert property (@(posedge clk) disable iff (rst)
    squash_vld |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/lsq_store_ring.sv
module lsq_store_ring #(
  parameter int USABLE = 5,
  parameter int SEQ_W  = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  localparam int SLOTS = USABLE + 1,
  localparam int W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_vld,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic              fill_vld,
  input  logic [W-1:0]      fill_idx,
  input  logic [SIZE_W-1:0] fill_size,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              commit_vld,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_vld,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              mem_block,
  input  logic              done_vld,
  input  logic [W-1:0]      done_idx,
  output logic              alloc_ok,
  output logic [W-1:0]      alloc_idx,
  output logic [W-1:0]      cnt,
  output logic              full,
  output logic [W-1:0]      pend,
  output logic              send_vld,
  output logic [W-1:0]      send_idx,
  output logic [SIZE_W-1:0] send_size,
  output logic [DATA_W-1:0] send_data
);
  import lsq_ring_pkg::*;

  st_flags_t         fl_q [SLOTS];
  st_flags_t         fl_d [SLOTS];
  logic [SEQ_W-1:0]  seq_q  [SLOTS];
  logic [DATA_W-1:0] data_mem [SLOTS];
  logic [SIZE_W-1:0] size_mem [SLOTS];
  logic [W-1:0]      head_q, tail_q, wb_q, cnt_q, pend_q;
  logic [SLOTS-1:0]  fill_hit, done_hit;
  logic              fill_ok, retire;
  int                rise, scnt;

  assign full      = (int'(cnt_q) == SLOTS - 1);
  assign alloc_ok  = alloc_vld && !full && !squash_vld;
  assign alloc_idx = tail_q;
  assign cnt       = cnt_q;
  assign pend      = pend_q;

  assign send_vld  = fl_q[wb_q].valid && fl_q[wb_q].can_wb &&
                     !fl_q[wb_q].completed && !mem_block;
  assign send_idx  = wb_q;
  assign send_data = data_mem[wb_q];
  assign send_size = size_mem[wb_q];
  assign retire    = fl_q[head_q].valid && fl_q[head_q].completed;

  always_comb begin
    st_flags_t f;
    rise = 0;
    scnt = 0;
    for (int i = 0; i < SLOTS; i++) begin
      f = fl_q[i];
      fill_hit[i] = fill_vld && fill_idx == W'(i) && f.valid && !f.sent;
      done_hit[i] = done_vld && done_idx == W'(i) && f.valid && f.sent && !f.completed;
      if (fill_hit[i]) f.filled = 1'b1;
      if (commit_vld && !squash_vld && f.valid && seq_q[i] < commit_seq)
        f.committed = 1'b1;
      if (f.committed && f.filled && !f.can_wb) begin
        f.can_wb = 1'b1;
        rise++;
      end
      if (send_vld && wb_q == W'(i)) f.sent = 1'b1;
      if (done_hit[i]) f.completed = 1'b1;
      if (retire && head_q == W'(i)) f = '0;
      if (squash_vld && fl_q[i].valid && !fl_q[i].committed && seq_q[i] > squash_seq) begin
        f = '0;
        scnt++;
      end
      if (alloc_ok && tail_q == W'(i)) begin
        f = '0;
        f.valid = 1'b1;
      end
      fl_d[i] = f;
    end
    fill_ok = |fill_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) fl_q[i] <= '0;
      head_q <= '0;
      tail_q <= '0;
      wb_q   <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) fl_q[i] <= fl_d[i];
      if (retire)   head_q <= W'(ring_step(int'(head_q), 1, SLOTS));
      if (send_vld) wb_q   <= W'(ring_step(int'(wb_q), 1, SLOTS));
      if (squash_vld)    tail_q <= W'(ring_step(int'(tail_q), -scnt, SLOTS));
      else if (alloc_ok) tail_q <= W'(ring_step(int'(tail_q), 1, SLOTS));
      cnt_q  <= W'(int'(cnt_q) + int'(alloc_ok) - int'(retire) - scnt);
      pend_q <= W'(int'(pend_q) + rise - int'(send_vld));
    end
  end

  // Payload storage without reset, single write port.
  always_ff @(posedge clk) begin
    if (fill_ok) begin
      data_mem[fill_idx] <= fill_data;
      size_mem[fill_idx] <= fill_size;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_ok) seq_q[tail_q] <= alloc_seq;
  end

  // R8: head stays while its store has not completed
  p_head_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fl_q[head_q].valid && !fl_q[head_q].completed) |=> head_q == $past(head_q));
  // R7: blocked memory side sees no offer
  p_block_r7: assert property (@(posedge clk) disable iff (rst)
    mem_block |-> !send_vld);
  // R7: an offer advances the writeback pointer
  p_wb_step_r7: assert property (@(posedge clk) disable iff (rst)
    send_vld |=> wb_q != $past(wb_q));
  // R6: pending stores are a subset of held stores
  p_pend_cap_r6: assert property (@(posedge clk) disable iff (rst)
    pend_q <= cnt_q);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot_chk
    // R8: completion only follows a send
    p_done_after_send_r8: assert property (@(posedge clk) disable iff (rst)
      fl_q[g].completed |-> fl_q[g].sent);
  end

endmodule

// File: rtl/lsq_ring_ctrl.sv
module lsq_ring_ctrl #(
  parameter int LD_USABLE = 7,
  parameter int ST_USABLE = 5,
  parameter int SEQ_W     = 16,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 4,
  localparam int LD_W  = $clog2(LD_USABLE + 1),
  localparam int ST_W  = $clog2(ST_USABLE + 1),
  localparam int MAXU  = (LD_USABLE > ST_USABLE) ? LD_USABLE : ST_USABLE,
  localparam int FR_W  = $clog2(MAXU + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_alloc_vld,
  input  logic [SEQ_W-1:0]  ld_alloc_seq,
  output logic              ld_alloc_ok,
  output logic [LD_W-1:0]   ld_alloc_idx,
  input  logic              st_alloc_vld,
  input  logic [SEQ_W-1:0]  st_alloc_seq,
  output logic              st_alloc_ok,
  output logic [ST_W-1:0]   st_alloc_idx,
  input  logic              st_fill_vld,
  input  logic [ST_W-1:0]   st_fill_idx,
  input  logic [SIZE_W-1:0] st_fill_size,
  input  logic [DATA_W-1:0] st_fill_data,
  input  logic              commit_vld,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_vld,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              mem_block,
  input  logic              mem_done_vld,
  input  logic [ST_W-1:0]   mem_done_idx,
  output logic              st_send_vld,
  output logic [ST_W-1:0]   st_send_idx,
  output logic [SIZE_W-1:0] st_send_size,
  output logic [DATA_W-1:0] st_send_data,
  output logic [LD_W-1:0]   ld_cnt,
  output logic [ST_W-1:0]   st_cnt,
  output logic              ld_full,
  output logic              st_full,
  output logic              lsq_full,
  output logic [FR_W-1:0]   free_cnt,
  output logic [ST_W-1:0]   st_wb_pend,
  output logic              st_wb_any
);

  lsq_load_ring #(.USABLE(LD_USABLE), .SEQ_W(SEQ_W)) u_ld (
    .clk(clk), .rst(rst),
    .alloc_vld(ld_alloc_vld), .alloc_seq(ld_alloc_seq),
    .commit_vld(commit_vld), .commit_seq(commit_seq),
    .squash_vld(squash_vld), .squash_seq(squash_seq),
    .alloc_ok(ld_alloc_ok), .alloc_idx(ld_alloc_idx),
    .cnt(ld_cnt), .full(ld_full)
  );

  lsq_store_ring #(.USABLE(ST_USABLE), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_st (
    .clk(clk), .rst(rst),
    .alloc_vld(st_alloc_vld), .alloc_seq(st_alloc_seq),
    .fill_vld(st_fill_vld), .fill_idx(st_fill_idx),
    .fill_size(st_fill_size), .fill_data(st_fill_data),
    .commit_vld(commit_vld), .commit_seq(commit_seq),
    .squash_vld(squash_vld), .squash_seq(squash_seq),
    .mem_block(mem_block), .done_vld(mem_done_vld), .done_idx(mem_done_idx),
    .alloc_ok(st_alloc_ok), .alloc_idx(st_alloc_idx),
    .cnt(st_cnt), .full(st_full), .pend(st_wb_pend),
    .send_vld(st_send_vld), .send_idx(st_send_idx),
    .send_size(st_send_size), .send_data(st_send_data)
  );

  assign lsq_full  = ld_full || st_full;
  assign st_wb_any = (st_wb_pend != '0);

  always_comb begin
    int lf, sf;
    lf = LD_USABLE - int'(ld_cnt);
    sf = ST_USABLE - int'(st_cnt);
    free_cnt = FR_W'((lf < sf) ? lf : sf);
  end

  // R4: a full unit accepts nothing more
  p_full_free_r4: assert property (@(posedge clk) disable iff (rst)
    lsq_full |-> free_cnt == '0);

endmodule

// File: tb/lsq_ring_ctrl_tb_top.sv
`timescale 1ns/1ps
module lsq_ring_ctrl_tb_top;
  localparam int LDU = 7, STU = 5, SEQ_W = 16, DATA_W = 32, SIZE_W = 4;
  localparam int LS = LDU + 1, SS = STU + 1;
  localparam int LD_W = $clog2(LS), ST_W = $clog2(SS);
  localparam int FR_W = $clog2(((LDU > STU) ? LDU : STU) + 1);

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic ld_alloc_vld = 0, st_alloc_vld = 0, st_fill_vld = 0, commit_vld = 0;
  logic squash_vld = 0, mem_block = 0, mem_done_vld = 0;
  logic [SEQ_W-1:0] ld_alloc_seq = 0, st_alloc_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [ST_W-1:0] st_fill_idx = 0, mem_done_idx = 0;
  logic [SIZE_W-1:0] st_fill_size = 0;
  logic [DATA_W-1:0] st_fill_data = 0;
  logic ld_alloc_ok, st_alloc_ok, st_send_vld, ld_full, st_full, lsq_full, st_wb_any;
  logic [LD_W-1:0] ld_alloc_idx, ld_cnt;
  logic [ST_W-1:0] st_alloc_idx, st_send_idx, st_cnt, st_wb_pend;
  logic [SIZE_W-1:0] st_send_size;
  logic [DATA_W-1:0] st_send_data;
  logic [FR_W-1:0] free_cnt;

  lsq_ring_ctrl #(.LD_USABLE(LDU), .ST_USABLE(STU), .SEQ_W(SEQ_W), .DATA_W(DATA_W),
                  .SIZE_W(SIZE_W)) dut_i (.*);

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // reference state
  bit l_vld[LS]; int l_seq[LS]; int lh = 0, lt = 0, lc = 0;
  bit s_vld[SS], s_fill[SS], s_comm[SS], s_can[SS], s_sent[SS], s_comp[SS];
  int s_seq[SS], s_size[SS]; logic [DATA_W-1:0] s_data[SS];
  int sh = 0, stl = 0, swb = 0, sc = 0, spend = 0;
  int nseq = 1, cb = 1;

  function automatic int wrp(input int p, input int slots);
    return (p % slots + slots) % slots;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state();
    int fr;
    fr = ((LDU - lc) < (STU - sc)) ? (LDU - lc) : (STU - sc);
    chk("R5 load count", int'(ld_cnt), lc);
    chk("R8 store count", int'(st_cnt), sc);
    chk("R3 load full", int'(ld_full), int'(lc == LDU));
    chk("R3 store full", int'(st_full), int'(sc == STU));
    chk("R3 unit full", int'(lsq_full), int'(lc == LDU || sc == STU));
    chk("R4 free count", int'(free_cnt), fr);
    chk("R6 pending count", int'(st_wb_pend), spend);
    chk("R6 pending flag", int'(st_wb_any), int'(spend != 0));
  endtask

  task automatic step(input bit ald, input bit ast, input bit fv, input int fi,
                      input int fsz, input logic [DATA_W-1:0] fdat, input bit cv,
                      input int cs, input bit sv, input int ss, input bit blk,
                      input bit dv, input int di);
    int lseq, sseq, p;
    bit exp_lok, exp_sok, exp_send, ret;
    lseq = nseq;
    sseq = ald ? nseq + 1 : nseq;
    nseq += 2;
    ld_alloc_vld = ald; ld_alloc_seq = SEQ_W'(lseq);
    st_alloc_vld = ast; st_alloc_seq = SEQ_W'(sseq);
    st_fill_vld = fv; st_fill_idx = ST_W'(fi); st_fill_size = SIZE_W'(fsz); st_fill_data = fdat;
    commit_vld = cv; commit_seq = SEQ_W'(cs);
    squash_vld = sv; squash_seq = SEQ_W'(ss);
    mem_block = blk; mem_done_vld = dv; mem_done_idx = ST_W'(di);
    #1;
    exp_lok = ald && lc < LDU && !sv;
    exp_sok = ast && sc < STU && !sv;
    chk("R2 R9 load accept", int'(ld_alloc_ok), int'(exp_lok));
    if (exp_lok) chk("R2 R10 load slot", int'(ld_alloc_idx), lt);
    chk("R2 R9 store accept", int'(st_alloc_ok), int'(exp_sok));
    if (exp_sok) chk("R2 R10 store slot", int'(st_alloc_idx), stl);
    exp_send = s_vld[swb] && s_can[swb] && !s_comp[swb] && !blk;
    chk("R7 send valid", int'(st_send_vld), int'(exp_send));
    if (exp_send) begin
      chk("R7 R10 send index", int'(st_send_idx), swb);
      chk("R7 send size", int'(st_send_size), s_size[swb]);
      chk("R7 send data", int'(st_send_data), int'(s_data[swb]));
    end
    // reference update
    ret = s_vld[sh] && s_comp[sh];
    if (fv && s_vld[fi] && !s_sent[fi]) begin
      s_fill[fi] = 1; s_data[fi] = fdat; s_size[fi] = fsz;
    end
    if (cv && !sv) begin
      while (lc > 0 && l_seq[lh] < cs) begin
        l_vld[lh] = 0; lh = wrp(lh + 1, LS); lc--;
      end
      for (int j = 0; j < SS; j++) if (s_vld[j] && s_seq[j] < cs) s_comm[j] = 1;
    end
    if (sv) begin
      p = wrp(lt - 1, LS);
      while (lc > 0 && l_seq[p] > ss) begin
        l_vld[p] = 0; lt = p; lc--; p = wrp(lt - 1, LS);
      end
      p = wrp(stl - 1, SS);
      while (s_vld[p] && !s_comm[p] && s_seq[p] > ss) begin
        s_vld[p] = 0; s_fill[p] = 0; stl = p; sc--; p = wrp(stl - 1, SS);
      end
    end
    for (int j = 0; j < SS; j++)
      if (s_comm[j] && s_fill[j] && !s_can[j]) begin s_can[j] = 1; spend++; end
    if (exp_send) begin s_sent[swb] = 1; swb = wrp(swb + 1, SS); spend--; end
    if (dv && s_vld[di] && s_sent[di] && !s_comp[di]) s_comp[di] = 1;
    if (ret) begin
      s_vld[sh] = 0; s_fill[sh] = 0; s_comm[sh] = 0; s_can[sh] = 0;
      s_sent[sh] = 0; s_comp[sh] = 0; sh = wrp(sh + 1, SS); sc--;
    end
    if (exp_lok) begin l_vld[lt] = 1; l_seq[lt] = lseq; lt = wrp(lt + 1, LS); lc++; end
    if (exp_sok) begin
      s_vld[stl] = 1; s_fill[stl] = 0; s_comm[stl] = 0; s_can[stl] = 0;
      s_sent[stl] = 0; s_comp[stl] = 0; s_seq[stl] = sseq; stl = wrp(stl + 1, SS); sc++;
    end
    if (cv && !sv && cs > cb) cb = cs;
    @(posedge clk); #1;
    check_state();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int fi, di, st0, cs, ss;
    bit fv, dv, cv, sv;
    void'($urandom(32'h1234_5a5a));
    for (int i = 0; i < SS; i++) begin s_vld[i] = 0; s_fill[i] = 0; s_comm[i] = 0;
      s_can[i] = 0; s_sent[i] = 0; s_comp[i] = 0; s_seq[i] = 0; s_size[i] = 0; s_data[i] = 0; end
    for (int i = 0; i < LS; i++) begin l_vld[i] = 0; l_seq[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    // R1: reset state
    chk("R1 load count", int'(ld_cnt), 0);
    chk("R1 store count", int'(st_cnt), 0);
    chk("R1 unit full", int'(lsq_full), 0);
    chk("R1 free count", int'(free_cnt), STU);
    chk("R1 pending", int'(st_wb_pend), 0);
    chk("R1 no offer", int'(st_send_vld), 0);
    // R3: fill the load ring past capacity
    for (int k = 0; k < LDU + 1; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: commit the three oldest loads (sequence 1, 3, 5)
    step(0, 0, 0, 0, 0, 0, 1, 7, 0, 0, 0, 0, 0);
    // R3: fill the store ring past capacity
    for (int k = 0; k < STU + 1; k++) step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < STU; k++) step(0, 0, 1, k, k + 1, 32'hA000 + k, 0, 0, 0, 0, 0, 0, 0);
    // R9: squash younger than all stores: committed boundary is 7, nothing committed yet among stores
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, nseq - 4, 0, 0, 0);
    // R6 R7: commit everything, hold memory blocked for a cycle
    step(0, 0, 0, 0, 0, 0, 1, nseq, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // random phase
    for (int it = 0; it < 4000; it++) begin
      fv = 0; fi = 0; dv = 0; di = 0;
      st0 = $urandom % SS;
      if ($urandom % 2 == 0)
        for (int k = 0; k < SS; k++) begin
          int j; j = (st0 + k) % SS;
          if (s_vld[j] && !s_fill[j]) begin fv = 1; fi = j; break; end
        end
      st0 = $urandom % SS;
      if ($urandom % 2 == 0)
        for (int k = 0; k < SS; k++) begin
          int j; j = (st0 + k) % SS;
          if (s_vld[j] && s_sent[j] && !s_comp[j]) begin dv = 1; di = j; break; end
        end
      cv = ($urandom % 100) < 25;
      cs = cb + int'($urandom % 6);
      if (cs > nseq) cs = nseq;
      sv = ($urandom % 100) < 5;
      ss = cb - 1 + int'($urandom % (nseq - cb + 2));
      step(($urandom % 100) < 45, ($urandom % 100) < 40, fv, fi, 1 + int'($urandom % 8),
           $urandom, cv, cs, sv, ss, ($urandom % 100) < 25, dv, di);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule